// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It watches a counter value supplied from outside, together with a tick strobe that marks each counter step. It compares that value against a programmable compare word and keeps an active-high reference bit. A 3-bit behaviour code decides what happens to the reference on a match. It can be left alone, set, cleared or inverted, or it can be held low or high no matter what the counter does.

A polarity bit maps the reference onto the pin. An external level-sensitive clear input can hold the reference low when its enable bit is set. A 2-bit direction field selects either output operation or one of three input sources. The pin is driven only in output operation with the channel enabled. The direction field cannot be changed while the channel is enabled.

Software loads an 8-bit control word and a compare word through two write strobes and reads both back. The counter, capture filtering, PWM and dead-time generation live elsewhere.

Top module: `oc_channel`

## Requirements
- R1: Synchronous active-high reset clears the reference, the compare word and the control word to 0. The control word layout is: bit 0 channel enable, bit 1 polarity, bits 3:2 direction, bits 6:4 behaviour code, bit 7 clear enable.
- R2: Behaviour codes 000, 110 and 111 leave the reference unchanged, even on a compare match.
- R3: With code 001, a match sets the reference to 1 from the cycle after the tick in which the counter value equals the compare word.
- R4: With code 010, a match clears the reference to 0 from the cycle after the match tick.
- R5: With code 011, each match inverts the reference in the cycle after the match tick.
- R6: Code 100 drives the reference to 0 and code 101 drives it to 1 one cycle after the code is loaded, without any match.
- R7: A match needs both an asserted tick and an equal value. An unequal value, or an equal value without a tick, leaves the reference unchanged under codes 001 to 011. The full counter range, including the all-ones value, can match.
- R8: When clear enable is 1 and the external clear input is high, the reference is 0 from the next cycle on. This overrides set, toggle and force-high, and it lasts as long as the input stays high.
- R9: When clear enable is 0, the external clear input has no effect on the reference.
- R10: The pin output equals reference XOR polarity when the direction is 00 and enable is 1. Otherwise it equals the polarity bit, which is the inactive level.
- R11: A control write updates every field, except that the direction field keeps its old value if the enable bit was 1 before the write.
- R12: The channel input output follows input source A for direction 01 and input source B for direction 10. For direction 11 it follows the internal trigger, but only when the trigger-valid input is high; otherwise it is 0. It is also 0 for direction 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Counter step strobe; compares only count in tick cycles |
| cnt_val | input | CNT_W | External counter value |
| ext_clr | input | 1 | External level-sensitive reference clear |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| cmp_we | input | 1 | Compare word write strobe |
| cmp_wdata | input | CNT_W | Compare word write data |
| in_a | input | 1 | Input source for direction 01 |
| in_b | input | 1 | Input source for direction 10 |
| in_trig | input | 1 | Internal trigger source for direction 11 |
| trig_ok | input | 1 | An internal trigger is selected upstream |
| ctl_rdata | output | 8 | Current control word |
| cmp_rdata | output | CNT_W | Current compare word |
| oc_ref | output | 1 | Active-high reference |
| oc_out | output | 1 | Pin output after polarity |
| chan_in | output | 1 | Selected input source |

## Verification
The bench builds the channel with an 8-bit counter width. This makes the all-ones compare value, 255, cheap to drive, so the top-of-range match is covered next to ordinary mid-range values. Near misses, such as an off-by-one value or an equal value without a tick, are placed right beside each real match. The bench also exercises clear priority over force-high, the direction lock, and every input-select code, including the trigger path with trigger-valid both low and high.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             ext_clr,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_trig,
  input  logic             trig_ok,
  output logic [7:0]       ctl_rdata,
  output logic [CNT_W-1:0] cmp_rdata,
  output logic             oc_ref,
  output logic             oc_out,
  output logic             chan_in
);

  logic             en, pol, clr_en;
  logic [1:0]       dir;
  logic [2:0]       code;
  logic [CNT_W-1:0] cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      pol    <= 1'b0;
      dir    <= 2'b00;
      code   <= 3'b000;
      clr_en <= 1'b0;
      cmp    <= '0;
    end else begin
      if (ctl_we) begin
        en     <= ctl_wdata[0];
        pol    <= ctl_wdata[1];
        if (!en) dir <= ctl_wdata[3:2];
        code   <= ctl_wdata[6:4];
        clr_en <= ctl_wdata[7];
      end
      if (cmp_we) cmp <= cmp_wdata;
    end
  end

  assign ctl_rdata = {clr_en, code, dir, pol, en};
  assign cmp_rdata = cmp;

  logic hit, clr_act;
  assign hit     = cnt_tick && (cnt_val == cmp);
  assign clr_act = clr_en && ext_clr;

  always_ff @(posedge clk) begin
    if (rst)          oc_ref <= 1'b0;
    else if (clr_act) oc_ref <= 1'b0;
    else begin
      case (code)
        3'b001:  if (hit) oc_ref <= 1'b1;
        3'b010:  if (hit) oc_ref <= 1'b0;
        3'b011:  if (hit) oc_ref <= ~oc_ref;
        3'b100:  oc_ref <= 1'b0;
        3'b101:  oc_ref <= 1'b1;
        default: ;
      endcase
    end
  end

  assign oc_out = (dir == 2'b00 && en) ? (oc_ref ^ pol) : pol;

  always_comb begin
    case (dir)
      2'b01:   chan_in = in_a;
      2'b10:   chan_in = in_b;
      2'b11:   chan_in = trig_ok & in_trig;
      default: chan_in = 1'b0;
    endcase
  end

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (oc_ref == 1'b0 && ctl_rdata == 8'h00)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((code == 3'b000 || code[2:1] == 2'b11) && !clr_act) |=> $stable(oc_ref)); // R2
  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b001 && hit && !clr_act) |=> oc_ref); // R3
  AST_CLR_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b010 && hit) |=> !oc_ref); // R4
  AST_TOGGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b011 && hit && !clr_act) |=> (oc_ref != $past(oc_ref))); // R5
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b101 && !clr_act) |=> oc_ref); // R6
  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (rst)
    (code == 3'b100) |=> !oc_ref); // R6
  AST_NO_HIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr_act && (code == 3'b001 || code == 3'b010 || code == 3'b011)) |=> $stable(oc_ref)); // R7
  AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (rst) clr_act |=> !oc_ref); // R8
  AST_DIR_LOCK: assert property (@(posedge clk) disable iff (rst)
    (en && ctl_we) |=> $stable(ctl_rdata[3:2])); // R11

endmodule

// File: tb/test_oc_channel.sv
module test_oc_channel;
  localparam int W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cnt_tick = 0, ext_clr = 0, ctl_we = 0, cmp_we = 0;
  logic [W-1:0] cnt_val = '0, cmp_wdata = '0;
  logic [7:0] ctl_wdata = '0;
  logic in_a = 0, in_b = 0, in_trig = 0, trig_ok = 0;
  logic [7:0] ctl_rdata;
  logic [W-1:0] cmp_rdata;
  logic oc_ref, oc_out, chan_in;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  oc_channel #(.CNT_W(W)) i_oc_channel (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .cnt_val(cnt_val), .ext_clr(ext_clr),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .in_a(in_a), .in_b(in_b), .in_trig(in_trig), .trig_ok(trig_ok),
    .ctl_rdata(ctl_rdata), .cmp_rdata(cmp_rdata), .oc_ref(oc_ref), .oc_out(oc_out),
    .chan_in(chan_in));

  function automatic logic [7:0] cw(input logic ce, input logic [2:0] cd,
                                    input logic [1:0] d, input logic p, input logic e);
    return {ce, cd, d, p, e};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wdata = d; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_cmp(input logic [W-1:0] d);
    cmp_wdata = d; cmp_we = 1;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic step(input logic [W-1:0] v, input logic t);
    cnt_val = v; cnt_tick = t;
    @(negedge clk); cnt_tick = 0;
  endtask

  task automatic t_reset;
    chk("R1 ref", oc_ref, 0);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 cmp", cmp_rdata, 0);
    chk("R1 out", oc_out, 0);
  endtask

  task automatic t_force;
    wr_ctl(cw(0, 3'b101, 0, 0, 0)); @(negedge clk);
    chk("R6 force high", oc_ref, 1);
    wr_ctl(cw(0, 3'b100, 0, 0, 0)); @(negedge clk);
    chk("R6 force low", oc_ref, 0);
  endtask

  task automatic t_set;
    wr_cmp(8'd5);
    chk("R1 cmp readback", cmp_rdata, 5);
    wr_ctl(cw(0, 3'b001, 0, 0, 0));
    step(8'd4, 1); chk("R7 unequal", oc_ref, 0);
    step(8'd5, 0); chk("R7 no tick", oc_ref, 0);
    step(8'd5, 1); chk("R3 set on match", oc_ref, 1);
    step(8'd5, 1); chk("R3 stays set", oc_ref, 1);
  endtask

  task automatic t_clear_match;
    wr_cmp(8'd255);
    wr_ctl(cw(0, 3'b010, 0, 0, 0));
    step(8'd254, 1); chk("R7 unequal keeps 1", oc_ref, 1);
    step(8'd255, 1); chk("R4 clear at max", oc_ref, 0);
  endtask

  task automatic t_toggle;
    wr_cmp(8'd9);
    wr_ctl(cw(0, 3'b011, 0, 0, 0));
    step(8'd9, 1); chk("R5 toggle 1", oc_ref, 1);
    step(8'd9, 0); chk("R7 no tick toggle", oc_ref, 1);
    step(8'd9, 1); chk("R5 toggle 2", oc_ref, 0);
  endtask

  task automatic t_hold;
    wr_ctl(cw(0, 3'b101, 0, 0, 0)); @(negedge clk);
    wr_ctl(cw(0, 3'b000, 0, 0, 0));
    step(8'd9, 1); chk("R2 hold 000", oc_ref, 1);
    wr_ctl(cw(0, 3'b110, 0, 0, 0));
    step(8'd9, 1); chk("R2 hold 110", oc_ref, 1);
    wr_ctl(cw(0, 3'b111, 0, 0, 0));
    step(8'd9, 1); chk("R2 hold 111", oc_ref, 1);
  endtask

  task automatic t_ext_clear;
    wr_ctl(cw(1, 3'b101, 0, 0, 0)); @(negedge clk);
    chk("R8 pre", oc_ref, 1);
    ext_clr = 1;
    @(negedge clk); chk("R8 clear over force high", oc_ref, 0);
    repeat (3) @(negedge clk);
    chk("R8 held low", oc_ref, 0);
    wr_ctl(cw(1, 3'b011, 0, 0, 0));
    step(8'd9, 1); chk("R8 clear over toggle", oc_ref, 0);
    ext_clr = 0;
    wr_ctl(cw(1, 3'b101, 0, 0, 0)); @(negedge clk);
    chk("R8 release", oc_ref, 1);
  endtask

  task automatic t_no_clear;
    wr_ctl(cw(0, 3'b101, 0, 0, 0));
    ext_clr = 1;
    repeat (2) @(negedge clk);
    chk("R9 clear ignored", oc_ref, 1);
    ext_clr = 0;
  endtask

  task automatic t_polarity;
    wr_ctl(cw(0, 3'b101, 0, 0, 1)); @(negedge clk);
    chk("R10 pol0 active", oc_out, 1);
    wr_ctl(cw(0, 3'b101, 0, 1, 1)); @(negedge clk);
    chk("R10 pol1 active", oc_out, 0);
    wr_ctl(cw(0, 3'b101, 0, 1, 0)); @(negedge clk);
    chk("R10 disabled inactive", oc_out, 1);
    wr_ctl(cw(0, 3'b101, 2'b01, 0, 0));
    wr_ctl(cw(0, 3'b101, 2'b01, 0, 1)); @(negedge clk);
    chk("R10 input dir inactive", oc_out, 0);
    wr_ctl(cw(0, 3'b000, 2'b01, 0, 0));
    wr_ctl(cw(0, 3'b000, 2'b00, 0, 0));
  endtask

  task automatic t_lock;
    wr_ctl(cw(0, 3'b000, 2'b00, 0, 1));
    wr_ctl(cw(0, 3'b010, 2'b10, 1, 1));
    chk("R11 dir locked", ctl_rdata[3:2], 2'b00);
    chk("R11 other fields", ctl_rdata, cw(0, 3'b010, 2'b00, 1, 1));
    wr_ctl(cw(0, 3'b000, 2'b11, 0, 0));
    chk("R11 still locked on disable", ctl_rdata[3:2], 2'b00);
    wr_ctl(cw(0, 3'b000, 2'b10, 0, 0));
    chk("R11 dir accepted", ctl_rdata[3:2], 2'b10);
  endtask

  task automatic t_inputs;
    wr_ctl(cw(0, 3'b000, 2'b01, 0, 0));
    in_a = 1; in_b = 0; #1; chk("R12 src A hi", chan_in, 1);
    in_a = 0; in_b = 1; #1; chk("R12 src A lo", chan_in, 0);
    wr_ctl(cw(0, 3'b000, 2'b10, 0, 0));
    chk("R12 src B", chan_in, 1);
    wr_ctl(cw(0, 3'b000, 2'b11, 0, 0));
    in_trig = 1; trig_ok = 0; #1; chk("R12 trig invalid", chan_in, 0);
    trig_ok = 1; #1; chk("R12 trig valid", chan_in, 1);
    wr_ctl(cw(0, 3'b000, 2'b00, 0, 0));
    chk("R12 output dir", chan_in, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_force;
    t_set;
    t_clear_match;
    t_toggle;
    t_hold;
    t_ext_clear;
    t_no_clear;
    t_polarity;
    t_lock;
    t_inputs;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule